// File: doc/BRIEF.md
# Fractional-N Pulse-Swallow Feedback Divider

This block is the programmable feedback divider of a fractional-N frequency synthesizer. It runs on the output clock of an external 32/33 dual-modulus prescaler. It drives the prescaler's modulus-select line, and it emits one comparison pulse per division cycle toward the phase detector. A division cycle lasts N prescaler clocks. During the first S of those clocks the prescaler divides by 33, and during the rest it divides by 32. One division cycle therefore spans 32*N + S oscillator periods.

The swallow count S is either A or A+1. A first-order accumulator modulo Q decides which one at the start of every division cycle. The modulus Q is 5 or 8 and is chosen at run time. The numerator F is added to the accumulator once per cycle, and each wrap adds one extra oscillator period. The average ratio is therefore 32*N + A + F/Q.

A setting (N, A, F, mode) is offered with a one-clock load strobe. An illegal setting is refused and flagged. A legal one waits in a holding register and is taken up at the next division-cycle boundary, so a cycle never mixes old and new values.

Top module: `frac_fb_divider`

## Requirements
- R1: While reset is high and just after it, `mod_ctl`, `cmp_pulse` and `cfg_err` are 0. The setting in force is N=34, A=0, F=0, Q=5, and the first division after reset lasts 34 prescaler clocks with `mod_ctl` low throughout.
- R2: Each division cycle lasts exactly N prescaler clocks. `cmp_pulse` is high for exactly one clock, the last clock of the cycle (main count at terminal value), so consecutive pulses are at least 34 clocks apart.
- R3: Within a division cycle, `mod_ctl` (1 = divide by 33, 0 = divide by 32) is high for the first S clocks and low for the remaining N-S. The cycle therefore spans 32*N + S oscillator periods, with S never above N.
- R4: At each boundary the accumulator takes acc+F. If that sum is Q or more, Q is subtracted and S = A+1 for the new cycle. Otherwise S = A. The accumulator stays below Q.
- R5: `cfg_mod8` = 1 selects Q = 8 and 0 selects Q = 5. Over any Q consecutive division cycles with a fixed setting, the oscillator periods total Q*(32*N + A) + F.
- R6: A loaded numerator F of Q or more is stored as Q-1.
- R7: A load with `cfg_main` below 34, or with `cfg_swal` above `cfg_main`, is refused. `cfg_err` is 1 on the clock after the strobe and the setting in force is unchanged. After an accepted load `cfg_err` is 0.
- R8: An accepted load made on a clock that is not the last clock of a division cycle applies from the next division cycle onward. The cycle in progress completes with the old setting.
- R9: When the Q taken up at a boundary differs from the Q used so far, the accumulator is cleared before F is added.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaler output clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | One-clock load strobe for a new setting |
| cfg_main | input | 10 | Main count N (34 to 1023) |
| cfg_swal | input | 5 | Swallow count A (0 to 31) |
| cfg_frac | input | 4 | Fractional numerator F |
| cfg_mod8 | input | 1 | Fractional modulus: 1 = 8, 0 = 5 |
| mod_ctl | output | 1 | Prescaler modulus select: 1 = divide by 33 |
| cmp_pulse | output | 1 | One-clock pulse on the last clock of each division cycle |
| cfg_err | output | 1 | One-clock flag after a refused load |

## Verification
The assertions check the cycle-local rules on every clock:
- the comparison pulse is one clock wide and has the minimum spacing;
- the modulus line never rises again once it has fallen within a cycle;
- the remaining swallow count fits in the remaining main count;
- the accumulator stays below Q;
- a refused load is always flagged, and the flag never appears without a strobe.

Only the bench's scenarios show the exact length and period total of each cycle for a given setting, and the Q-cycle average including saturated numerators. They also show that settings are deferred to the next boundary, that a refused load leaves the old setting in force, and that the accumulator is cleared when the modulus changes.

// File: rtl/frac_div_pkg.sv
package frac_div_pkg;

    localparam int MAIN_W   = 10;
    localparam int SWAL_W   = 5;
    localparam int FRAC_W   = 4;
    localparam int ACC_W    = FRAC_W;
    localparam int MAIN_MIN = 34;
    localparam int Q_LO     = 5;
    localparam int Q_HI     = 8;

    typedef struct packed {
        logic [MAIN_W-1:0] main;
        logic [SWAL_W-1:0] swal;
        logic [FRAC_W-1:0] frac;
        logic              mod8;
    } div_cfg_t;

    localparam div_cfg_t CFG_RESET = '{
        main: MAIN_W'(MAIN_MIN),
        swal: '0,
        frac: '0,
        mod8: 1'b0
    };

    function automatic logic [FRAC_W-1:0] modulus(input logic mod8);
        return mod8 ? FRAC_W'(Q_HI) : FRAC_W'(Q_LO);
    endfunction

    function automatic logic [FRAC_W-1:0] sat_frac(input logic [FRAC_W-1:0] f,
                                                   input logic mod8);
        logic [FRAC_W-1:0] q;
        q = modulus(mod8);
        return (f >= q) ? (q - 1'b1) : f;
    endfunction

    function automatic logic cfg_legal(input div_cfg_t c);
        logic [MAIN_W-1:0] swal_ext;
        swal_ext = {{(MAIN_W-SWAL_W){1'b0}}, c.swal};
        return (c.main >= MAIN_W'(MAIN_MIN)) && (swal_ext <= c.main);
    endfunction

endpackage

// File: rtl/div_cfg_stage.sv
module div_cfg_stage
    import frac_div_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     we,
    input  div_cfg_t cfg_in,
    output div_cfg_t pend_o,
    output logic     err_o
);
    div_cfg_t pend_q;
    div_cfg_t cleaned;
    logic     err_q;

    always_comb begin
        cleaned      = cfg_in;
        cleaned.frac = sat_frac(cfg_in.frac, cfg_in.mod8);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= CFG_RESET;
            err_q  <= 1'b0;
        end else begin
            err_q <= 1'b0;
            if (we) begin
                if (cfg_legal(cfg_in)) begin
                    pend_q <= cleaned;
                end else begin
                    err_q <= 1'b1;
                end
            end
        end
    end

    assign pend_o = pend_q;
    assign err_o  = err_q;
endmodule

// File: rtl/frac_accum.sv
module frac_accum
    import frac_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic [FRAC_W-1:0] frac,
    input  logic              mod8,
    output logic              carry,
    output logic [ACC_W-1:0]  acc_o,
    output logic              mod8_o
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] base;
    logic [ACC_W-1:0] acc_nxt;
    logic [ACC_W:0]   sum;
    logic [ACC_W:0]   qx;
    logic             mod8_q;

    always_comb begin
        base    = (mod8 != mod8_q) ? '0 : acc_q;
        qx      = {1'b0, modulus(mod8)};
        sum     = {1'b0, base} + {1'b0, frac};
        carry   = (sum >= qx);
        acc_nxt = carry ? ACC_W'(sum - qx) : ACC_W'(sum);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            mod8_q <= 1'b0;
        end else if (step) begin
            acc_q  <= acc_nxt;
            mod8_q <= mod8;
        end
    end

    assign acc_o  = acc_q;
    assign mod8_o = mod8_q;
endmodule

// File: rtl/swallow_main_ctr.sv
module swallow_main_ctr
    import frac_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [MAIN_W-1:0] load_main,
    input  logic [SWAL_W:0]   load_swal,
    output logic              tc,
    output logic              mod_hi,
    output logic [MAIN_W-1:0] main_left,
    output logic [SWAL_W:0]   swal_left
);
    logic [MAIN_W-1:0] main_q;
    logic [SWAL_W:0]   swal_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            main_q <= MAIN_W'(MAIN_MIN - 1);
            swal_q <= '0;
        end else if (tc) begin
            main_q <= load_main - 1'b1;
            swal_q <= load_swal;
        end else begin
            main_q <= main_q - 1'b1;
            if (swal_q != '0) begin
                swal_q <= swal_q - 1'b1;
            end
        end
    end

    assign tc        = (main_q == '0);
    assign mod_hi    = (swal_q != '0);
    assign main_left = main_q;
    assign swal_left = swal_q;
endmodule

// File: rtl/frac_fb_divider.sv
module frac_fb_divider
    import frac_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [MAIN_W-1:0] cfg_main,
    input  logic [SWAL_W-1:0] cfg_swal,
    input  logic [FRAC_W-1:0] cfg_frac,
    input  logic              cfg_mod8,
    output logic              mod_ctl,
    output logic              cmp_pulse,
    output logic              cfg_err
);
    div_cfg_t          cfg_in;
    div_cfg_t          pend;
    logic              tc;
    logic              carry;
    logic [SWAL_W:0]   swal_next;
    logic [ACC_W-1:0]  acc_state;
    logic              acc_mod8;
    logic [MAIN_W-1:0] main_left;
    logic [SWAL_W:0]   swal_left;

    assign cfg_in = '{main: cfg_main, swal: cfg_swal, frac: cfg_frac, mod8: cfg_mod8};

    div_cfg_stage u_cfg (
        .clk    (clk),
        .rst    (rst),
        .we     (cfg_we),
        .cfg_in (cfg_in),
        .pend_o (pend),
        .err_o  (cfg_err)
    );

    frac_accum u_acc (
        .clk    (clk),
        .rst    (rst),
        .step   (tc),
        .frac   (pend.frac),
        .mod8   (pend.mod8),
        .carry  (carry),
        .acc_o  (acc_state),
        .mod8_o (acc_mod8)
    );

    assign swal_next = {1'b0, pend.swal} + (SWAL_W+1)'(carry);

    swallow_main_ctr u_ctr (
        .clk       (clk),
        .rst       (rst),
        .load_main (pend.main),
        .load_swal (swal_next),
        .tc        (tc),
        .mod_hi    (mod_ctl),
        .main_left (main_left),
        .swal_left (swal_left)
    );

    assign cmp_pulse = tc;
endmodule

// File: rtl/frac_fb_divider_chk.sv
module frac_fb_divider_chk
    import frac_div_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic [MAIN_W-1:0] cfg_main,
    input logic [SWAL_W-1:0] cfg_swal,
    input logic              mod_ctl,
    input logic              cmp_pulse,
    input logic              cfg_err,
    input logic [ACC_W-1:0]  acc_state,
    input logic              acc_mod8,
    input logic [MAIN_W-1:0] main_left,
    input logic [SWAL_W:0]   swal_left
);
    logic [MAIN_W:0] gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap <= '0;
        end else if (cmp_pulse) begin
            gap <= '0;
        end else if (gap != '1) begin
            gap <= gap + 1'b1;
        end
    end

    AST_PULSE_ONE_WIDE: assert property (@(posedge clk) disable iff (rst)
        cmp_pulse |=> !cmp_pulse); // R2

    AST_PULSE_SPACING: assert property (@(posedge clk) disable iff (rst)
        cmp_pulse |-> (gap >= (MAIN_W+1)'(MAIN_MIN - 1))); // R2

    AST_MOD_STAYS_LOW: assert property (@(posedge clk) disable iff (rst)
        (!mod_ctl && !cmp_pulse) |=> !mod_ctl); // R3

    AST_SWALLOW_FITS: assert property (@(posedge clk) disable iff (rst)
        ({{(MAIN_W-SWAL_W){1'b0}}, swal_left} <= ({1'b0, main_left} + 1'b1))); // R3

    AST_ACC_BELOW_Q: assert property (@(posedge clk) disable iff (rst)
        acc_state < modulus(acc_mod8)); // R4

    AST_BAD_LOAD_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && ((cfg_main < MAIN_W'(MAIN_MIN)) ||
                    ({{(MAIN_W-SWAL_W){1'b0}}, cfg_swal} > cfg_main))) |=> cfg_err); // R7

    AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        cfg_err |-> $past(cfg_we)); // R7
endmodule

bind frac_fb_divider frac_fb_divider_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_main  (cfg_main),
    .cfg_swal  (cfg_swal),
    .mod_ctl   (mod_ctl),
    .cmp_pulse (cmp_pulse),
    .cfg_err   (cfg_err),
    .acc_state (acc_state),
    .acc_mod8  (acc_mod8),
    .main_left (main_left),
    .swal_left (swal_left)
);

// File: tb/sim_frac_fb_divider.sv
`timescale 1ns/1ps
module sim_frac_fb_divider;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [9:0] cfg_main = '0;
    logic [4:0] cfg_swal = '0;
    logic [3:0] cfg_frac = '0;
    logic       cfg_mod8 = 1'b0;
    logic       mod_ctl, cmp_pulse, cfg_err;

    always #2 clk = ~clk;

    frac_fb_divider u0 (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_main(cfg_main),
        .cfg_swal(cfg_swal), .cfg_frac(cfg_frac), .cfg_mod8(cfg_mod8),
        .mod_ctl(mod_ctl), .cmp_pulse(cmp_pulse), .cfg_err(cfg_err)
    );

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 0;

    // model of the holding register and of the cycle in progress
    int  pend_n = 34, pend_a = 0, pend_f = 0;
    bit  pend_m8 = 0;
    bit  act_m8 = 0;
    int  m_acc = 0;
    int  exp_len = 34, exp_s = 0;
    int  run_cyc = 0, run_hi = 0;
    longint run_vco = 0;
    bit  seen_low = 0;
    int  div_done = 0;
    int  load_mark = 0;
    bit  win_on = 0;
    int  win_cnt = 0;
    longint win_sum = 0;

    function automatic int q_of(bit m8);
        return m8 ? 8 : 5;
    endfunction

    function automatic int sat_f(int f, bit m8);
        return (f >= q_of(m8)) ? q_of(m8) - 1 : f;
    endfunction

    function automatic bit legal(int n, int a);
        return (n >= 34) && (a <= n);
    endfunction

    task automatic check(bit ok, string tag, longint act, longint expv);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic finish_report();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
            $finish;
        end
    endtask

    // per-cycle monitor, sampled on the falling edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            run_cyc++;
            run_vco += mod_ctl ? 33 : 32;
            if (mod_ctl) begin
                run_hi++;
                if (seen_low) check(0, "R3 modulus rose again in cycle", 1, 0);
            end else begin
                seen_low = 1;
            end
            if (cmp_pulse) begin
                check(run_cyc == exp_len, "R2 R8 division length", run_cyc, exp_len);
                check(run_hi == exp_s, "R3 R4 swallow clocks", run_hi, exp_s);
                check(run_vco == 32*exp_len + exp_s, "R3 period total",
                      run_vco, 32*exp_len + exp_s);
                if (win_on) begin
                    win_sum += run_vco;
                    win_cnt++;
                end
                // next cycle from the model, R4 and R9
                if (pend_m8 != act_m8) m_acc = 0;
                act_m8 = pend_m8;
                m_acc += pend_f;
                if (m_acc >= q_of(act_m8)) begin
                    m_acc -= q_of(act_m8);
                    exp_s = pend_a + 1;
                end else begin
                    exp_s = pend_a;
                end
                exp_len = pend_n;
                run_cyc = 0; run_hi = 0; run_vco = 0; seen_low = 0;
                div_done++;
            end
        end
    end

    task automatic do_load(int n, int a, int f, bit m8);
        bit ok;
        @(negedge clk);
        while (cmp_pulse) @(negedge clk);
        ok = legal(n, a);
        cfg_we = 1'b1;
        cfg_main = n[9:0]; cfg_swal = a[4:0]; cfg_frac = f[3:0]; cfg_mod8 = m8;
        load_mark = div_done;
        if (ok) begin
            pend_n = n; pend_a = a; pend_f = sat_f(f, m8); pend_m8 = m8;
        end
        @(negedge clk);
        cfg_we = 1'b0;
        check(cfg_err == !ok, "R7 refusal flag", cfg_err, !ok);
    endtask

    task automatic wait_after_load(int k);
        wait (div_done >= load_mark + k);
    endtask

    // sum of Q cycles after the load applies, R5
    task automatic window(int n, int a, int f, bit m8, string tag);
        int q;
        longint expv;
        q = q_of(m8);
        wait (div_done >= load_mark + 1);
        win_sum = 0; win_cnt = 0; win_on = 1;
        wait (win_cnt == q);
        win_on = 0;
        expv = longint'(q) * (32*n + a) + sat_f(f, m8);
        check(win_sum == expv, tag, win_sum, expv);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog expired", 0, 1);
        finish_report();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(mod_ctl == 0, "R1 mod_ctl in reset", mod_ctl, 0);
        check(cmp_pulse == 0, "R1 cmp_pulse in reset", cmp_pulse, 0);
        check(cfg_err == 0, "R1 cfg_err in reset", cfg_err, 0);
        @(posedge clk) rst <= 1'b0;
        @(negedge clk);
        check(mod_ctl == 0 && cmp_pulse == 0, "R1 outputs after reset",
              {mod_ctl, cmp_pulse}, 0);
        wait (div_done >= 2);   // R1: first cycle of 34 checked by monitor

        // directed corners
        do_load(34, 31, 0, 0);
        window(34, 31, 0, 0, "R5 R3 N=34 A=31 Q=5");
        do_load(33, 5, 2, 1);   // R7: refused, old setting stays
        window(34, 31, 0, 0, "R7 R5 refused load keeps setting");
        do_load(20, 31, 1, 0);  // R7: A above N
        window(34, 31, 0, 0, "R7 A above N refused");
        do_load(1023, 0, 7, 1);
        window(1023, 0, 7, 1, "R5 N=1023 Q=8 F=7");
        do_load(50, 10, 13, 0); // R6: 13 becomes 4
        window(50, 10, 13, 0, "R6 R5 saturated numerator Q=5");
        do_load(45, 2, 9, 1);   // R6: 9 becomes 7
        window(45, 2, 9, 1, "R6 R5 saturated numerator Q=8");
        do_load(40, 3, 7, 1);
        wait_after_load(4);
        do_load(40, 3, 3, 0);   // R9: modulus change clears accumulator
        window(40, 3, 3, 0, "R9 R5 after modulus change");

        // constrained random settings, loads land mid-cycle (R8)
        for (int i = 0; i < 120; i++) begin
            int n, a, f;
            bit m8;
            if ($urandom % 16 == 0) n = $urandom % 34;
            else if ($urandom % 25 == 0) n = 1023;
            else n = 34 + ($urandom % 160);
            a = $urandom % 32;
            f = $urandom % 16;
            m8 = 1'($urandom % 2);
            do_load(n, a, f, m8);
            wait_after_load(1 + ($urandom % 2));
            if (i % 30 == 0) window(pend_n, pend_a, pend_f, pend_m8, "R5 random window");
        end
        wait_after_load(3);
        finish_report();
    end
endmodule